// File: doc/BRIEF.md
# Four-Plane Pixel Shifter

This block converts planar video memory words into a stream of 4-bit colour indices. A memory controller places 16-bit words on a data bus and marks each one with a one-cycle load strobe. The block keeps a small load position that selects which of four plane latches takes the word. On the fourth word of a group, all four planes move together into four shift registers. From the next cycle on, each pixel clock takes one bit from every plane, starting at the most significant bit, and puts them together as a colour index.

A display-enable input controls only whether pixels are shown. Raising display-enable does not reset anything. The load position returns to its first slot only when a load strobe arrives while display-enable is low, which puts the plane order back in line for the next scanline. The shifter counts the bits left in the current group. Display-enable may therefore rise several clocks before the first load of a line without stale bits being shown as valid pixels.

Top module: `planar_pixel_shifter`

## Requirements
- R1: After a synchronous active-high reset, `colourIdx` is 0 and `pixelValid` is 0, and the load position is at its first slot (plane 0).
- R2: A load strobe with `dispEn` high writes `dataIn` into the plane latch chosen by the load position. The position then advances 0, 1, 2, 3 and wraps back to 0.
- R3: The load that fills plane 3 moves all four planes into the shift registers. In the cycle after that edge, pixel 0 is shown. Pixel k (k = 0..15) is `{plane3[15-k], plane2[15-k], plane1[15-k], plane0[15-k]}`, with one pixel per clock.
- R4: Once all 16 pixels of a group have been shown, `pixelValid` is 0 and `colourIdx` is 0 until the next transfer. This also covers a display-enable lead of 8 clocks with no loads.
- R5: While `dispEn` is low, `colourIdx` is 0 and `pixelValid` is 0. The shift registers keep shifting, so a group resumes at the pixel that matches the elapsed clocks.
- R6: A rise of `dispEn`, or any cycle without a load strobe, leaves the load position and the latches unchanged.
- R7: A load strobe with `dispEn` low sets the load position back to plane 0 and writes no latch.
- R8: A transfer that happens while a group is still shifting replaces the remaining bits. With the next group's loads timed to the last four pixels, pixel 0 of the new group directly follows pixel 15 of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| dispEn | input | 1 | Display enable; low blanks the output and arms realignment |
| loadStrobe | input | 1 | Marks a valid word on `dataIn` |
| dataIn | input | 16 | Plane word from memory |
| colourIdx | output | 4 | Colour index {plane3, plane2, plane1, plane0} |
| pixelValid | output | 1 | High when `colourIdx` carries a real pixel |

## Verification
The assertions assume that a load strobe lasts one cycle per word and that the controller delivers a full group of four words, unless it is deliberately realigning. They also assume that `dispEn` does not fall in the middle of a group that is meant to be shown. The directed stimulus drives inputs on the falling edge and keeps loads to single-cycle pulses. It breaks the group size only in the misalignment scenario, and that scenario realigns with a load while display-enable is low before it checks any pixel.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int NUM_PLANES = 4;
  localparam int POS_W      = $clog2(NUM_PLANES);

  typedef struct packed {
    logic [NUM_PLANES-1:0] latchEn;
    logic                  transfer;
  } ctrlStrobes_t;
endpackage

// File: rtl/pps_load_ctrl.sv
module pps_load_ctrl
  import pps_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         dispEn,
  input  logic         loadStrobe,
  output ctrlStrobes_t strobes
);
  logic [POS_W-1:0] loadPos;
  logic             lastSlot;

  assign lastSlot = (loadPos == POS_W'(NUM_PLANES - 1));

  always_comb begin
    strobes = '0;
    if (loadStrobe && dispEn) begin
      strobes.latchEn[loadPos] = 1'b1;
      strobes.transfer         = lastSlot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadPos <= '0;
    end else if (loadStrobe) begin
      if (!dispEn || lastSlot) loadPos <= '0;
      else                     loadPos <= loadPos + 1'b1;
    end
  end

  // R7: a strobe while blanked realigns the sequence
  a_r7_realign: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && !dispEn) |=> (loadPos == '0));

  // R6: without a strobe the position holds, whatever dispEn does
  a_r6_hold_pos: assert property (@(posedge clk) disable iff (rst)
    !loadStrobe |=> $stable(loadPos));

  // R2: an accepted load always fires exactly one latch enable
  a_r2_one_latch: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && dispEn) |-> ($countones(strobes.latchEn) == 1));

  // R7: no latch is written while blanked
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    !dispEn |-> (strobes.latchEn == '0));
endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dispEn,
  input  ctrlStrobes_t          strobes,
  input  logic [WORD_W-1:0]     dataIn,
  output logic [NUM_PLANES-1:0] colourIdx,
  output logic                  pixelValid
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]      bitsLeft;
  logic [NUM_PLANES-1:0] msbBits;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [WORD_W-1:0] latchQ;
    logic [WORD_W-1:0] shiftQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        latchQ <= '0;
        shiftQ <= '0;
      end else begin
        if (strobes.latchEn[p]) latchQ <= dataIn;
        if (strobes.transfer)
          shiftQ <= strobes.latchEn[p] ? dataIn : latchQ;
        else
          shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
      end
    end

    assign msbBits[p] = shiftQ[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst)                   bitsLeft <= '0;
    else if (strobes.transfer) bitsLeft <= CNT_W'(WORD_W);
    else if (bitsLeft != '0)   bitsLeft <= bitsLeft - 1'b1;
  end

  assign pixelValid = dispEn && (bitsLeft != '0);
  assign colourIdx  = pixelValid ? msbBits : '0;

  // R3: a transfer arms a full group of pixels
  a_r3_full_group: assert property (@(posedge clk) disable iff (rst)
    strobes.transfer |=> (bitsLeft == CNT_W'(WORD_W)));

  // R8: the bit counter never exceeds one word
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    bitsLeft <= CNT_W'(WORD_W));

  // R4: an exhausted group stays exhausted until the next transfer
  a_r4_stay_empty: assert property (@(posedge clk) disable iff (rst)
    ((bitsLeft == '0) && !strobes.transfer) |=> (bitsLeft == '0));
endmodule

// File: rtl/planar_pixel_shifter.sv
module planar_pixel_shifter
  import pps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dispEn,
  input  logic                  loadStrobe,
  input  logic [WORD_W-1:0]     dataIn,
  output logic [NUM_PLANES-1:0] colourIdx,
  output logic                  pixelValid
);
  ctrlStrobes_t strobes;

  pps_load_ctrl u_ctrl (
    .clk(clk), .rst(rst), .dispEn(dispEn),
    .loadStrobe(loadStrobe), .strobes(strobes)
  );

  pps_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .dispEn(dispEn), .strobes(strobes),
    .dataIn(dataIn), .colourIdx(colourIdx), .pixelValid(pixelValid)
  );

  // R5: blanking forces a zero, invalid output
  a_r5_blank: assert property (@(posedge clk) disable iff (rst)
    !dispEn |-> (colourIdx == '0 && !pixelValid));

  // R4: an invalid pixel is always shown as zero
  a_r4_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !pixelValid |-> (colourIdx == '0));
endmodule

// File: tb/planar_pixel_shifter_bench.sv
`timescale 1ns/1ps
module planar_pixel_shifter_bench;
  logic clk = 1'b0;
  logic rst, dispEn, loadStrobe;
  logic [15:0] dataIn;
  logic [3:0]  colourIdx;
  logic        pixelValid;
  int checks = 0, errors = 0;
  logic [15:0] grp [4];

  always #2.5 clk = ~clk;

  planar_pixel_shifter u_planar_pixel_shifter (
    .clk(clk), .rst(rst), .dispEn(dispEn), .loadStrobe(loadStrobe),
    .dataIn(dataIn), .colourIdx(colourIdx), .pixelValid(pixelValid)
  );

  task automatic check(string req, logic [3:0] idx, logic vld,
                       logic [3:0] expIdx, logic expVld);
    checks++;
    if (idx !== expIdx || vld !== expVld) begin
      errors++;
      $display("FAIL %s: idx=%h valid=%b expected idx=%h valid=%b",
               req, idx, vld, expIdx, expVld);
    end
  endtask

  function automatic logic [3:0] pix(logic [15:0] w0, logic [15:0] w1,
                                      logic [15:0] w2, logic [15:0] w3, int k);
    return {w3[15-k], w2[15-k], w1[15-k], w0[15-k]};
  endfunction

  task automatic loadWord(logic [15:0] w);
    @(negedge clk); loadStrobe = 1'b1; dataIn = w;
  endtask

  task automatic idle();
    @(negedge clk); loadStrobe = 1'b0; dataIn = '0;
  endtask

  // loads four words; returns at the negedge where pixel 0 is shown
  task automatic loadGroup(logic [15:0] a, logic [15:0] b,
                           logic [15:0] c, logic [15:0] d);
    loadWord(a); loadWord(b); loadWord(c); loadWord(d); idle();
  endtask

  task automatic checkPixels(string req, int first, int last);
    for (int k = first; k <= last; k++) begin
      if (k != first) @(negedge clk);
      check(req, colourIdx, pixelValid, pix(grp[0], grp[1], grp[2], grp[3], k), 1'b1);
    end
  endtask

  task automatic testReset();
    rst = 1'b1; dispEn = 1'b0; loadStrobe = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", colourIdx, pixelValid, 4'h0, 1'b0);
  endtask

  task automatic testLeadAndGroup();
    dispEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R4 lead no stale", colourIdx, pixelValid, 4'h0, 1'b0);
    end
    grp[0] = 16'hA5F0; grp[1] = 16'h3C0F; grp[2] = 16'hFF00; grp[3] = 16'h1234;
    loadGroup(grp[0], grp[1], grp[2], grp[3]);
    checkPixels("R2/R3 group", 0, 15);
    @(negedge clk);
    check("R4 exhausted", colourIdx, pixelValid, 4'h0, 1'b0);
  endtask

  task automatic testBlankMidGroup();
    grp[0] = 16'hFFFF; grp[1] = 16'h0F0F; grp[2] = 16'hAAAA; grp[3] = 16'h8001;
    loadGroup(grp[0], grp[1], grp[2], grp[3]);
    checkPixels("R3 group2", 0, 3);
    dispEn = 1'b0;
    for (int k = 4; k < 8; k++) begin
      @(negedge clk);
      check("R5 blanked", colourIdx, pixelValid, 4'h0, 1'b0);
    end
    dispEn = 1'b1;
    @(negedge clk);
    checkPixels("R5 resume", 8, 15);
    idle();
  endtask

  task automatic testSeamless();
    logic [15:0] nxt [4];
    grp[0] = 16'h1111; grp[1] = 16'h2222; grp[2] = 16'h4444; grp[3] = 16'h8888;
    nxt[0] = 16'hC3C3; nxt[1] = 16'h5A5A; nxt[2] = 16'h0FF0; nxt[3] = 16'hF00F;
    loadGroup(grp[0], grp[1], grp[2], grp[3]);
    checkPixels("R3 group3", 0, 11);
    for (int k = 12; k < 16; k++) begin
      @(negedge clk);
      check("R8 old tail", colourIdx, pixelValid,
            pix(grp[0], grp[1], grp[2], grp[3], k), 1'b1);
      loadStrobe = 1'b1; dataIn = nxt[k-12];
    end
    for (int i = 0; i < 4; i++) grp[i] = nxt[i];
    idle();
    checkPixels("R8 seamless", 0, 15);
    idle();
  endtask

  task automatic testHoldAcrossRise();
    repeat (17) @(negedge clk);
    grp[0] = 16'h0001; grp[1] = 16'h8000; grp[2] = 16'h7FFE; grp[3] = 16'hBEEF;
    loadWord(grp[0]); loadWord(grp[1]); idle();
    dispEn = 1'b0;
    repeat (3) @(negedge clk);
    dispEn = 1'b1;
    repeat (8) @(negedge clk);
    check("R6 no pixels yet", colourIdx, pixelValid, 4'h0, 1'b0);
    loadWord(grp[2]); loadWord(grp[3]); idle();
    checkPixels("R6 position kept", 0, 15);
    idle();
  endtask

  task automatic testRealign();
    repeat (17) @(negedge clk);
    loadWord(16'hDEAD); loadWord(16'hBEEF); idle();
    dispEn = 1'b0;
    loadWord(16'h5555);
    idle();
    check("R7 realign strobe blanked", colourIdx, pixelValid, 4'h0, 1'b0);
    dispEn = 1'b1;
    repeat (8) @(negedge clk);
    check("R7 lead after realign", colourIdx, pixelValid, 4'h0, 1'b0);
    grp[0] = 16'h9876; grp[1] = 16'hCAFE; grp[2] = 16'h0F1E; grp[3] = 16'h7331;
    loadGroup(grp[0], grp[1], grp[2], grp[3]);
    checkPixels("R7 realigned group", 0, 15);
    idle();
  endtask

  initial begin
    testReset();
    testLeadAndGroup();
    testBlankMidGroup();
    testSeamless();
    testHoldAcrossRise();
    testRealign();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule